// File: doc/BRIEF.md
# Convolutional Byte De-interleaver with Sync Anchoring

This block undoes the twelve-way convolutional byte interleaving applied to 204-byte transport blocks. Aligned bytes arrive one per `in_valid` strobe, and a start flag marks the sync byte of each block. The block deals the bytes round-robin over twelve branches. Each branch delays its bytes by a multiple of 17 branch writes: the branch that takes the sync byte has the longest delay and the last branch passes its byte straight through. The output is the original byte order, together with a flag that marks the first byte of each recovered block.

All branch delays share one RAM of 1122 bytes. Each branch owns a fixed region of that RAM and a circular pointer inside it. A start flag always steers its byte into branch 0 and restarts the commutator there. Output bytes are marked valid only once the longest branch has been filled with data from after the anchoring start flag. A start flag that arrives while the commutator is away from branch 0 is reported as a misalignment and re-anchors the block.

Top module: `conv_deinterleaver`

## Requirements
- R1: Until the first start flag after reset, accepted bytes are discarded and `out_valid` stays 0.
- R2: A byte with the start flag goes to branch 0. Each accepted byte advances the commutator by one branch, and after branch 11 it wraps back to branch 0.
- R3: Branch j delays its bytes by (11-j)*17 writes to that branch. Together with a matching interleaver, the output stream equals the original byte stream delayed by 2244 accepted bytes, byte for byte.
- R4: After an anchoring start, `out_valid` is 0 for the first 2244 accepted bytes (indices 0 to 2243) and is 1 for every later one. Each output appears one clock after its input byte.
- R5: `out_start` is 1 exactly on the output bytes that are the first byte of a 204-byte block, which is where the sync byte sits, and only when `out_valid` is 1.
- R6: A start flag accepted while the block is anchored and the commutator is not at branch 0 gives a one-cycle `misalign` pulse on the next clock. The commutator is forced to branch 0 and the fill window of R4 starts again.
- R7: A start flag that arrives at branch 0 gives no `misalign` pulse and leaves the output stream undisturbed.
- R8: Cycles with `in_valid` at 0 do not advance the commutator or the pointers. `out_valid` is only 1 in the cycle after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_start | input | 1 | Marks the sync byte of a block |
| in_data | input | W | Interleaved input byte |
| out_valid | output | 1 | Output byte is valid |
| out_start | output | 1 | Output byte is the first byte of a block |
| out_data | output | W | De-interleaved byte |
| misalign | output | 1 | Start flag seen away from branch 0 |

## Verification
The hardest situation to reach from the ports is a start flag that arrives mid-cycle of the commutator after the pipeline is already full. Reaching it needs a complete stream with its full 2244-byte fill, followed by a few bytes that leave the commutator away from branch 0. The bench streams fourteen packets through a behavioural interleaver, with random gaps between strobes. It then appends five more bytes and starts a fresh stream whose first sync byte lands on branch 5. This exercises the misalignment pulse, the forced return to branch 0, and a second full fill window. Byte-exact comparison against the delayed original stream confirms both the recovery and the exact moment `out_valid` rises.

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver #(
  parameter int W        = 8,
  parameter int BRANCHES = 12,
  parameter int STEP     = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_start,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic         out_start,
  output logic [W-1:0] out_data,
  output logic         misalign
);
  localparam int LAST  = BRANCHES - 1;
  localparam int DEPTH = STEP * BRANCHES * LAST / 2;
  localparam int FILL  = LAST * STEP * BRANCHES;
  localparam int BLOCK = BRANCHES * STEP;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(LAST * STEP + 1);
  localparam int BW    = $clog2(BRANCHES);
  localparam int CW    = $clog2(FILL + 1);
  localparam int KW    = $clog2(BLOCK);

  function automatic logic [AW-1:0] region_base(input int j);
    return AW'(STEP * (j * LAST - (j * (j - 1)) / 2));
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr [BRANCHES];
  logic [BW-1:0] br;
  logic [KW-1:0] blk;
  logic [CW-1:0] cnt;
  logic          anchored;

  wire           restart  = in_start && (!anchored || br != '0);
  wire           accept   = in_valid && (anchored || in_start);
  wire [BW-1:0]  eb       = in_start ? '0 : br;
  wire [KW-1:0]  eblk     = in_start ? '0 : blk;
  wire [CW-1:0]  ecnt     = restart ? '0 : cnt;
  wire           through  = (eb == BW'(LAST));
  wire [PW-1:0]  cur_len  = PW'((LAST - int'(eb)) * STEP);
  wire [PW-1:0]  cur_ptr  = ptr[eb];
  wire [PW-1:0]  nxt_ptr  = (cur_ptr + 1'b1 == cur_len) ? '0 : cur_ptr + 1'b1;
  wire [AW-1:0]  addr     = region_base(int'(eb)) + AW'(cur_ptr);
  wire           full     = (ecnt == CW'(FILL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br        <= '0;
      blk       <= '0;
      cnt       <= '0;
      anchored  <= 1'b0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      misalign  <= 1'b0;
      for (int j = 0; j < BRANCHES; j++) ptr[j] <= '0;
    end else begin
      out_valid <= accept && full;
      out_start <= accept && full && (eblk == '0);
      misalign  <= accept && in_start && anchored && (br != '0);
      if (accept) begin
        anchored <= 1'b1;
        br       <= through ? '0 : eb + 1'b1;
        blk      <= (eblk == KW'(BLOCK - 1)) ? '0 : eblk + 1'b1;
        cnt      <= full ? ecnt : ecnt + 1'b1;
        if (!through) ptr[eb] <= nxt_ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_data <= through ? in_data : mem[addr];
      if (!through) mem[addr] <= in_data;
    end
  end

  assert_unanchored_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!anchored && !(in_valid && in_start)) |=> !out_valid);
  assert_start_to_branch0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> (br == BW'(1)));
  assert_valid_needs_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  assert_start_marks_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
  assert_refill_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && restart) |=> !out_valid);
  assert_misalign_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> $past(in_valid && in_start));
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(br));
endmodule

// File: tb/conv_deinterleaver_tb_top.sv
module conv_deinterleaver_tb_top;
  localparam int FILL = 2244;
  localparam int BLK  = 204;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, in_valid, in_start;
  logic [7:0] in_data;
  logic       out_valid, out_start, misalign;
  logic [7:0] out_data;

  conv_deinterleaver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .out_valid(out_valid), .out_start(out_start),
    .out_data(out_data), .misalign(misalign)
  );

  typedef struct packed { logic [7:0] d; logic s; } exp_t;
  logic [7:0] txq [12][$];
  logic [7:0] hist [$];
  exp_t       expq [$];
  int  checks = 0, fails = 0, k = 0, outs = 0;
  bit  cur_valid = 0, cur_mis = 0, seen_valid = 0;

  task automatic tx_reset();
    for (int j = 0; j < 12; j++) begin
      txq[j].delete();
      for (int n = 0; n < j * 17; n++) txq[j].push_back(8'h00);
    end
    hist.delete();
    k = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_start = 0; cur_valid = 0; cur_mis = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit mis);
    logic [7:0] o;
    int j;
    if ($urandom_range(0, 3) == 0) idle();
    @(negedge clk);
    j = k % 12;
    txq[j].push_back(b);
    in_data  = txq[j].pop_front();
    in_valid = 1;
    in_start = (k % BLK == 0);
    cur_valid = 1;
    cur_mis  = mis;
    hist.push_back(b);
    if (k >= FILL) begin
      o = hist.pop_front();
      expq.push_back({o, (k % BLK) == 0});
    end
    k++;
  endtask

  task automatic stream(input int pkts, input bit first_mis);
    for (int p = 0; p < pkts; p++)
      for (int i = 0; i < BLK; i++)
        send((i == 0) ? 8'h47 : 8'($urandom), first_mis && p == 0 && i == 0);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin
        exp_t e;
        seen_valid = 1;
        check(cur_valid, "R8 out_valid without input byte", 0, 1);
        if (expq.size() == 0)
          check(0, "R1 R4 R6 out_valid during fill/unanchored", 1, 0);
        else begin
          e = expq.pop_front();
          outs++;
          check(out_data === e.d, "R3 R2 data", out_data, e.d);
          check(out_start === e.s, "R5 block start", out_start, e.s);
        end
      end else if (out_start) check(0, "R5 out_start without valid", 1, 0);
      if (cur_valid) check(misalign === cur_mis, "R6 R7 misalign", misalign, cur_mis);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_start = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 0 && out_start === 0 && misalign === 0, "reset outputs", out_valid, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      in_valid = 1; in_start = 0; in_data = 8'($urandom); cur_valid = 1; cur_mis = 0;
    end
    idle(); idle();
    check(seen_valid == 0, "R1 output before first start", seen_valid, 0);
    tx_reset();
    outs = 0;
    stream(14, 0);
    for (int i = 0; i < 5; i++) send(8'($urandom), 0);
    idle(); idle();
    check(outs == 14 * BLK + 5 - FILL, "R4 valid output count", outs, 14 * BLK + 5 - FILL);
    check(expq.size() == 0, "R4 pending expectations", expq.size(), 0);
    expq.delete();
    tx_reset();
    outs = 0;
    stream(14, 1);
    idle(); idle();
    check(outs == 14 * BLK - FILL, "R6 refill output count", outs, 14 * BLK - FILL);
    check(expq.size() == 0, "R6 pending expectations", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule